// File: doc/BRIEF.md
# Configurable Logic Cell

A single logic cell of a programmable array. A static configuration word, held stable while the cell runs, sets what it computes. A 32-bit truth table yields two function values, F and G. The table can serve as two independent four-variable functions, one five-variable function, or a seven-variable function formed by choosing between its two halves. Any table address bit can be taken from the five logic inputs or fed back from the cell's own two flip-flops. Neighbouring cells consume the two outputs, X and Y.

Each flip-flop loads F, G or the data input on the cell's active clock edge. The configuration chooses that edge, rising or falling, by inverting the incoming clock. The two flip-flops share three controls: a hold-type clock enable, an asynchronous direct clear, and a global active-low reset. The direct clear and the enable take effect only when the configuration enables them.

Top module: `lut_cell`

## Requirements
- R1: Each table address bit comes from a 3-bit variable select: 0 to 4 pick logic input bits 0 to 4, 5 picks flip-flop X, 6 picks flip-flop Y, 7 gives constant 0. The select at index i of the F (or G) select list drives address bit i of that function.
- R2: With mode code 0 or 3 (split), F is table bit number fIndex and G is table bit number 16 + gIndex.
- R3: With mode code 1, F and G both equal table bit number 16*v + fIndex, where v is the variable picked by the fifth-variable select.
- R4: With mode code 2, F and G both equal table bit 16 + gIndex when the fifth variable is 1, and table bit fIndex when it is 0. The indices may include the flip-flop feedback.
- R5: The flip-flop X source code (and likewise Y) loads F for code 0, G for code 1, and the data input for codes 2 and 3.
- R6: The output X select code loads F for 0, G for 1, and flip-flop X for 2 or 3. Output Y does the same with flip-flop Y.
- R7: When the direct-clear use bit is 1 and the direct clear is high, both flip-flops go to 0 at once and stay 0 across clock edges. When the use bit is 0, the direct clear has no effect.
- R8: A low global reset clears both flip-flops whatever the configuration.
- R9: When the enable use bit is 1 and the clock enable is low, both flip-flops keep their state across an active edge. When the use bit is 0, the clock enable is ignored.
- R10: With the clock-invert bit at 0 the flip-flops update on the rising clock edge; with it at 1 they update on the falling edge.
- R11: Configuration word layout from MSB down: table bits [71:40] (bit n is entry n), mode [39:38], F selects [37:26] (index 3 highest), G selects [25:14], fifth-variable select [13:11], X source [10:9], Y source [8:7], output X select [6:5], output Y select [4:3], direct-clear use [2], enable use [1], clock invert [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming cell clock before polarity choice |
| rstN | input | 1 | Global reset, active low, asynchronous |
| cfg | input | 72 | Static configuration word (layout in R11) |
| logicIn | input | 5 | Logic inputs, bit 0 to bit 4 |
| dataIn | input | 1 | Direct data input for the flip-flops |
| clkEn | input | 1 | Shared clock enable, low holds state |
| dirClr | input | 1 | Shared direct clear, active high, asynchronous |
| outX | output | 1 | Cell output X |
| outY | output | 1 | Cell output Y |
| stateX | output | 1 | Flip-flop X state |
| stateY | output | 1 | Flip-flop Y state |

## Verification
A wrong flip-flop state reaches the ports right away through stateX and stateY. It also reaches outX and outY whenever an output select or a feedback address bit uses that state. A missed clear or a wrongly honoured hold therefore shows up at the first sample after the edge. With feedback-based functions the error then spreads into every later table lookup. A clock-polarity fault can only be seen between the two clock edges, so every cycle samples the state once mid-cycle, in addition to the sample taken after the full cycle.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
package lut_cell_pkg;
  localparam int unsigned NUM_IN   = 5;
  localparam int unsigned FN_VARS  = 4;
  localparam int unsigned LUT_DEPTH = 2 ** (FN_VARS + 1);
  localparam int unsigned POOL_W   = NUM_IN + 3;
  localparam int unsigned SEL_W    = $clog2(POOL_W);
  localparam int unsigned SRC_W    = 2;

  typedef enum logic [1:0] {
    MODE_SPLIT     = 2'd0,
    MODE_FIVE      = 2'd1,
    MODE_SEVEN     = 2'd2,
    MODE_SPLIT_ALT = 2'd3
  } cellMode_e;

  typedef struct packed {
    logic [LUT_DEPTH-1:0]              lutBits;
    cellMode_e                         mode;
    logic [FN_VARS-1:0][SEL_W-1:0]     fSel;
    logic [FN_VARS-1:0][SEL_W-1:0]     gSel;
    logic [SEL_W-1:0]                  fifthSel;
    logic [SRC_W-1:0]                  qxSrc;
    logic [SRC_W-1:0]                  qySrc;
    logic [SRC_W-1:0]                  xSrc;
    logic [SRC_W-1:0]                  ySrc;
    logic                              rdUse;
    logic                              ecUse;
    logic                              clkInv;
  } cellCfg_t;

  localparam int unsigned CFG_W = $bits(cellCfg_t);

  typedef struct packed {
    logic cellClk;
    logic cellClr;
    logic hold;
  } cellStrobe_t;
endpackage

// File: rtl/lut_cell_ctrl.sv
`timescale 1ns/1ps
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cellCfg_t    cfgS,
  input  logic        clkEn,
  input  logic        dirClr,
  output cellStrobe_t strb
);
  // Polarity choice: one phase distributed, inverted locally when asked.
  logic edgeClk;
  assign edgeClk = clk ^ cfgS.clkInv;

  // Clear sources: global reset always, direct clear only when enabled.
  logic localClr;
  assign localClr = cfgS.rdUse & dirClr;

  // Hold when the enable is in use and driven low.
  logic holdReq;
  assign holdReq = cfgS.ecUse & ~clkEn;

  always_comb begin
    strb.cellClk = edgeClk;
    strb.cellClr = ~rstN | localClr;
    strb.hold    = holdReq;
  end
endmodule

// File: rtl/lut_cell_dp.sv
`timescale 1ns/1ps
module lut_cell_dp
  import lut_cell_pkg::*;
(
  input  cellCfg_t          cfgS,
  input  cellStrobe_t       strb,
  input  logic [NUM_IN-1:0] logicIn,
  input  logic              dataIn,
  output logic              fnF,
  output logic              fnG,
  output logic              stateX,
  output logic              stateY,
  output logic              outX,
  output logic              outY
);
  localparam int unsigned NUM_FF = 2;

  logic [NUM_FF-1:0] ffQ;
  logic [NUM_FF-1:0] ffD;
  logic [POOL_W-1:0] varPool;
  logic [FN_VARS-1:0] fIdx;
  logic [FN_VARS-1:0] gIdx;
  logic fifthVar;
  logic lowHalf, highHalf, fullVal;

  // Variable pool: logic inputs, then feedback, constant zero on top.
  assign varPool = {1'b0, ffQ[1], ffQ[0], logicIn};

  for (genvar i = 0; i < FN_VARS; i++) begin : g_addr
    assign fIdx[i] = varPool[cfgS.fSel[i]];
    assign gIdx[i] = varPool[cfgS.gSel[i]];
  end
  assign fifthVar = varPool[cfgS.fifthSel];

  assign lowHalf  = cfgS.lutBits[{1'b0, fIdx}];
  assign highHalf = cfgS.lutBits[{1'b1, gIdx}];
  assign fullVal  = cfgS.lutBits[{fifthVar, fIdx}];

  always_comb begin
    unique case (cfgS.mode)
      MODE_FIVE: begin
        fnF = fullVal;
        fnG = fullVal;
      end
      MODE_SEVEN: begin
        fnF = fifthVar ? highHalf : lowHalf;
        fnG = fnF;
      end
      default: begin
        fnF = lowHalf;
        fnG = highHalf;
      end
    endcase
  end

  // Flip-flop data selection and storage, one slice per flip-flop.
  logic [NUM_FF-1:0][SRC_W-1:0] ffSrc;
  assign ffSrc[0] = cfgS.qxSrc;
  assign ffSrc[1] = cfgS.qySrc;

  logic cellClk, cellClr, holdNow;
  assign cellClk = strb.cellClk;
  assign cellClr = strb.cellClr;
  assign holdNow = strb.hold;

  for (genvar k = 0; k < NUM_FF; k++) begin : g_ff
    always_comb begin
      unique case (ffSrc[k])
        2'd0:    ffD[k] = fnF;
        2'd1:    ffD[k] = fnG;
        default: ffD[k] = dataIn;
      endcase
    end

    always_ff @(posedge cellClk or posedge cellClr) begin
      if (cellClr)       ffQ[k] <= 1'b0;
      else if (!holdNow) ffQ[k] <= ffD[k];
    end
  end

  assign stateX = ffQ[0];
  assign stateY = ffQ[1];

  always_comb begin
    unique case (cfgS.xSrc)
      2'd0:    outX = fnF;
      2'd1:    outX = fnG;
      default: outX = ffQ[0];
    endcase
    unique case (cfgS.ySrc)
      2'd0:    outY = fnF;
      2'd1:    outY = fnG;
      default: outY = ffQ[1];
    endcase
  end
endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [NUM_IN-1:0] logicIn,
  input  logic              dataIn,
  input  logic              clkEn,
  input  logic              dirClr,
  output logic              outX,
  output logic              outY,
  output logic              stateX,
  output logic              stateY
);
  cellCfg_t    cfgS;
  cellStrobe_t strb;
  logic        fnF, fnG;

  // Configuration must be settled before rstN is released.
  assign cfgS = cellCfg_t'(cfg);

  lut_cell_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgS   (cfgS),
    .clkEn  (clkEn),
    .dirClr (dirClr),
    .strb   (strb)
  );

  lut_cell_dp u_dp (
    .cfgS    (cfgS),
    .strb    (strb),
    .logicIn (logicIn),
    .dataIn  (dataIn),
    .fnF     (fnF),
    .fnG     (fnG),
    .stateX  (stateX),
    .stateY  (stateY),
    .outX    (outX),
    .outY    (outY)
  );
endmodule

// File: rtl/lut_cell_chk.sv
`timescale 1ns/1ps
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfg,
  input logic             dataIn,
  input logic             clkEn,
  input logic             dirClr,
  input logic             outX,
  input logic             outY,
  input logic             stateX,
  input logic             stateY,
  input logic             fnF,
  input logic             fnG
);
  cellCfg_t cfgS;
  assign cfgS = cellCfg_t'(cfg);

  logic activeEdge;
  assign activeEdge = clk ^ cfgS.clkInv;

  // R7: an enabled direct clear keeps both flip-flops at zero
  a_r7_direct_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgS.rdUse && dirClr) |-> (!stateX && !stateY));

  // R9: a hold at an active edge leaves the state unchanged
  a_r9_hold_state: assert property (@(posedge activeEdge)
    disable iff (!rstN || (cfgS.rdUse && dirClr))
    (cfgS.ecUse && !clkEn) |=> ($stable(stateX) && $stable(stateY)));

  // R5: a data-input source loads the value present at the edge
  a_r5_din_load: assert property (@(posedge activeEdge)
    disable iff (!rstN || (cfgS.rdUse && dirClr))
    (!(cfgS.ecUse && !clkEn) && cfgS.qxSrc[1]) |=> (stateX == $past(dataIn)));

  // R6: output selects that name a flip-flop follow it
  a_r6_x_follows_ff: assert property (@(posedge clk) disable iff (!rstN)
    cfgS.xSrc[1] |-> (outX == stateX));
  a_r6_y_follows_ff: assert property (@(posedge clk) disable iff (!rstN)
    cfgS.ySrc[1] |-> (outY == stateY));

  // R3 and R4: the joined modes present one value on both functions
  a_r3_joined_fn: assert property (@(posedge clk) disable iff (!rstN)
    (cfgS.mode == MODE_FIVE || cfgS.mode == MODE_SEVEN) |-> (fnF == fnG));
endmodule

bind lut_cell lut_cell_chk u_chk (.*);

// File: tb/lut_cell_tb.sv
`timescale 1ns/1ps
module lut_cell_tb;
  import lut_cell_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic [NUM_IN-1:0] logicIn = '0;
  logic dataIn = 1'b0, clkEn = 1'b1, dirClr = 1'b0;
  logic outX, outY, stateX, stateY;

  always #2 clk = ~clk;

  lut_cell u_dut (.*);

  typedef struct {
    logic  x, y, qx, qy;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, errors = 0;
  bit done = 0;
  cellCfg_t cur;
  logic mQx = 1'b0, mQy = 1'b0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference function generator written from R1 to R4.
  function automatic void refFn(input cellCfg_t c, input logic [7:0] pool,
                                output logic f, output logic g);
    logic [3:0] fi, gi;
    logic v;
    for (int i = 0; i < 4; i++) begin
      fi[i] = (c.fSel[i] == 3'd7) ? 1'b0 : pool[c.fSel[i]];
      gi[i] = (c.gSel[i] == 3'd7) ? 1'b0 : pool[c.gSel[i]];
    end
    v = (c.fifthSel == 3'd7) ? 1'b0 : pool[c.fifthSel];
    if (c.mode == 2'd1) begin
      f = c.lutBits[v ? 16 + int'(fi) : int'(fi)];
      g = f;
    end else if (c.mode == 2'd2) begin
      f = v ? c.lutBits[16 + int'(gi)] : c.lutBits[int'(fi)];
      g = f;
    end else begin
      f = c.lutBits[int'(fi)];
      g = c.lutBits[16 + int'(gi)];
    end
  endfunction

  function automatic logic pickSrc(input logic [1:0] s, input logic f, input logic g, input logic d);
    return (s == 2'd0) ? f : (s == 2'd1) ? g : d;
  endfunction

  // Driver: one cycle of stimulus, prediction pushed to the scoreboard.
  task automatic drive(input string tag, input int pRd, input int pRst);
    logic f, g, nx, ny, clr;
    expItem_t it;
    @(posedge clk); #1.5;
    logicIn = NUM_IN'($urandom);
    dataIn  = 1'($urandom);
    clkEn   = ($urandom % 100) < 60;
    dirClr  = ($urandom % 100) < pRd;
    rstN    = !(($urandom % 100) < pRst);
    clr = !rstN || (cur.rdUse && dirClr);
    refFn(cur, {1'b0, mQy, mQx, logicIn}, f, g);
    if (clr) begin nx = 0; ny = 0; end
    else if (cur.ecUse && !clkEn) begin nx = mQx; ny = mQy; end
    else begin
      nx = pickSrc(cur.qxSrc, f, g, dataIn);
      ny = pickSrc(cur.qySrc, f, g, dataIn);
    end
    refFn(cur, {1'b0, ny, nx, logicIn}, f, g);
    it.qx = nx; it.qy = ny;
    it.x = cur.xSrc[1] ? nx : (cur.xSrc[0] ? g : f);
    it.y = cur.ySrc[1] ? ny : (cur.ySrc[0] ? g : f);
    it.tag = tag;
    expQ.push_back(it);
    // Mid-cycle: only the falling edge has passed (R10).
    #1.5;
    chk(clr ? "R7" : "R10", "midX", stateX, clr ? 1'b0 : (cur.clkInv ? nx : mQx));
    chk(clr ? "R7" : "R10", "midY", stateY, clr ? 1'b0 : (cur.clkInv ? ny : mQy));
    mQx = nx; mQy = ny;
  endtask

  // Monitor: compares after exactly one edge of each polarity.
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk); #0.5;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        chk(it.tag, "outX",   outX,   it.x);
        chk(it.tag, "outY",   outY,   it.y);
        chk(it.tag, "stateX", stateX, it.qx);
        chk(it.tag, "stateY", stateY, it.qy);
      end
    end
  end

  task automatic loadCfg(input cellCfg_t c);
    @(posedge clk); #1.5;
    rstN = 1'b0; dirClr = 1'b0;
    cur = c; cfg = c;
    mQx = 0; mQy = 0;
    #4;
    chk("R8", "rstX", stateX, 1'b0);
    chk("R8", "rstY", stateY, 1'b0);
  endtask

  function automatic cellCfg_t randCfg();
    cellCfg_t c;
    c = cellCfg_t'({$urandom, $urandom, $urandom});
    return c;
  endfunction

  task automatic phase(input string tag, input int which, input int pRd, input int pRst);
    cellCfg_t c;
    for (int n = 0; n < 8; n++) begin
      c = randCfg();
      case (which)
        2: begin
          c.mode = (n % 2) ? MODE_SPLIT_ALT : MODE_SPLIT;
          for (int i = 0; i < 4; i++) begin
            c.fSel[i] = 3'($urandom_range(0, 4));
            c.gSel[i] = 3'($urandom_range(0, 4));
          end
        end
        3: c.mode = MODE_FIVE;
        4: begin
          c.mode = MODE_SEVEN; c.fSel[0] = 3'd5; c.gSel[1] = 3'd6;
          c.qxSrc = 2'($urandom_range(0, 1)); c.qySrc = 2'($urandom_range(0, 1));
        end
        7: c.rdUse = n[0];
        9: c.ecUse = n[0];
        10: c.clkInv = n[0];
        default: ;
      endcase
      loadCfg(c);
      for (int s = 0; s < 30; s++) drive(tag, pRd, (s == 0) ? 0 : pRst);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase("R2", 2, 0, 0);
    phase("R3", 3, 0, 0);
    phase("R4", 4, 5, 0);
    phase("R1", 0, 5, 0);
    phase("R5", 0, 5, 0);
    phase("R6", 0, 5, 0);
    phase("R7", 7, 35, 0);
    phase("R8", 0, 5, 25);
    phase("R9", 9, 10, 0);
    phase("R10", 10, 5, 0);
    phase("R11", 0, 10, 5);
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule